// File: doc/BRIEF.md
# Multiprocessor Bus Request Arbiter

This block is the arbitration unit placed in every node that shares one external bus with up to five peers and a host. All nodes run identical logic. Each reads the same wired request lines and holds its own identity, so every node reaches the same decision about ownership without a central arbiter. A node drives only the request line chosen by its identity. It watches all the lines and tracks which line currently owns the bus. A shared mode input selects fixed or rotating priority, and all nodes must see it change in the same cycle.

A host request outranks every peer. While the host requests the bus, ownership is frozen. The current owner first floats its address, data, select and strobe drivers and then asserts an active-low grant, which it holds until the host lets go. A shared active-low core-priority line lets a slave node whose core needs the bus push aside requests that exist only for background DMA.

Top module: `mpa_bus_arbiter`

## Requirements
- R1: Identity k (1..6) is captured while reset is low and held after that. The node drives only bit k-1 of `req_n_o` (active low) and keeps every other bit high. Changing `node_id_i` after reset has no effect.
- R2: An identity of 0, or a value above 6, selects single-node operation. In that case `bus_master_o` is always 1 and `req_n_o` stays all ones.
- R3: With `rotate_i` low, a change of owner goes to the asserted line with the lowest index.
- R4: With `rotate_i` high, the search for a new owner starts at the line just after the present owner and wraps around, so the last owner has the lowest priority.
- R5: Ownership does not change while the owner's request line is asserted.
- R6: After reset the owner is line index 0, the node with identity 1. If no lines are asserted, the owner stays the same.
- R7: While `host_req_n_i` is low, ownership is frozen. The owner raises `bus_float_o` at the first edge at which it samples the host request.
- R8: `host_grant_n_o` goes low one edge after `bus_float_o` rises. It stays low while the host request is held. At the first edge that samples the request released, the grant goes high and `bus_float_o` goes low at that same edge.
- R9: Only the owner drives `host_grant_n_o` low. Non-owners keep it high, and `bus_float_o` is never high on a non-owner.
- R10: A non-owner with `core_req_i` high drives `core_prio_n_o` low. While `core_prio_n_i` is low, a request that rests only on `dma_req_i` is withdrawn from the request line, and an owner holding the bus only for DMA releases it.
- R11: In a system of nodes with identities 1 to 6, exactly one node reports `bus_master_o` high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; identity is captured while low |
| node_id_i | input | 3 | Node identity (0 = single node, 1..6 = request line) |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| req_lines_n_i | input | 6 | Shared wired request lines, active low, bit k-1 is identity k |
| req_n_o | output | 6 | This node's contribution to the request lines, active low |
| core_req_i | input | 1 | Local core wants the external bus |
| dma_req_i | input | 1 | Local background DMA wants the external bus |
| core_prio_n_i | input | 1 | Shared core-priority line, active low |
| core_prio_n_o | output | 1 | This node's drive of the core-priority line, active low |
| host_req_n_i | input | 1 | Host bus request, active low |
| host_grant_n_o | output | 1 | Host grant drive, active low, only from the owner |
| bus_float_o | output | 1 | 1 = this node's external bus drivers are in high impedance |
| bus_master_o | output | 1 | 1 = this node owns the bus |

## Verification
Six nodes sit on wired-AND request and core-priority lines, and a seventh node runs in single-node mode. Overlapping requests are applied under fixed priority and under rotating priority. The rotating cases put one requester on each side of the current owner, so that the two orders pick different winners. Host episodes are started while peers are requesting, which separates a real freeze of ownership from a change after release and shows the float-then-grant order. The DMA-only against core cases tell the core-priority path apart from ordinary priority. A long pseudo-random run then mixes all of these inputs against a behavioural model.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    localparam int unsigned MPA_LINES = 6;
    localparam int unsigned MPA_ID_W  = 3;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;

    typedef struct packed {
        logic float_en;
        logic grant;
    } host_seq_t;

endpackage

// File: rtl/mpa_id_decode.sv
module mpa_id_decode #(
    parameter int unsigned N_LINES = mpa_pkg::MPA_LINES,
    parameter int unsigned ID_W    = mpa_pkg::MPA_ID_W,
    localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [ID_W-1:0]    id_i,
    output logic [N_LINES-1:0] own_line_o,
    output logic [IDX_W-1:0]   own_idx_o,
    output logic               single_o
);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        assign own_line_o[g] = (id_i == ID_W'(g + 1));
    end

    assign single_o  = ~(|own_line_o);
    assign own_idx_o = IDX_W'(id_i - ID_W'(1));

endmodule

// File: rtl/mpa_prio_pick.sv
module mpa_prio_pick #(
    parameter int unsigned N_LINES = mpa_pkg::MPA_LINES,
    localparam int unsigned IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] req_i,
    input  logic [IDX_W-1:0]   last_idx_i,
    input  logic               rotate_i,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic               win_vld_o
);

    int start;
    int cand;

    always_comb begin
        win_idx_o = '0;
        win_vld_o = 1'b0;
        cand      = 0;
        start     = rotate_i ? ((int'(last_idx_i) + 1) % int'(N_LINES)) : 0;
        for (int k = 0; k < int'(N_LINES); k++) begin
            cand = (start + k) % int'(N_LINES);
            if (!win_vld_o && req_i[cand]) begin
                win_vld_o = 1'b1;
                win_idx_o = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/mpa_host_seq.sv
module mpa_host_seq
    import mpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic host_act_i,
    output logic float_o,
    output logic grant_o
);

    host_seq_t hs_d, hs_q;

    always_comb begin
        hs_d          = hs_q;
        hs_d.float_en = host_act_i & master_i;
        hs_d.grant    = host_act_i & master_i & hs_q.float_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign float_o = hs_q.float_en;
    assign grant_o = hs_q.grant;

endmodule

// File: rtl/mpa_bus_arbiter.sv
module mpa_bus_arbiter
    import mpa_pkg::*;
#(
    parameter int unsigned N_LINES = MPA_LINES,
    parameter int unsigned ID_W    = MPA_ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    node_id_i,
    input  logic               rotate_i,
    input  logic [N_LINES-1:0] req_lines_n_i,
    output logic [N_LINES-1:0] req_n_o,
    input  logic               core_req_i,
    input  logic               dma_req_i,
    input  logic               core_prio_n_i,
    output logic               core_prio_n_o,
    input  logic               host_req_n_i,
    output logic               host_grant_n_o,
    output logic               bus_float_o,
    output logic               bus_master_o
);

    localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] owner;
        logic [ID_W-1:0]  id;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N_LINES-1:0] own_line;
    logic [IDX_W-1:0]   own_idx;
    logic               single;
    logic [N_LINES-1:0] line_act;
    logic [IDX_W-1:0]   win_idx;
    logic               win_vld;
    logic               eff_req;
    logic               host_act;
    logic               grant;
    prio_mode_e         mode;

    mpa_id_decode #(
        .N_LINES (N_LINES),
        .ID_W    (ID_W)
    ) u_dec (
        .id_i       (st_q.id),
        .own_line_o (own_line),
        .own_idx_o  (own_idx),
        .single_o   (single)
    );

    assign mode     = prio_mode_e'(rotate_i);
    assign line_act = ~req_lines_n_i;
    assign host_act = ~host_req_n_i;

    mpa_prio_pick #(
        .N_LINES (N_LINES)
    ) u_pick (
        .req_i      (line_act),
        .last_idx_i (st_q.owner),
        .rotate_i   (mode == PRIO_ROTATE),
        .win_idx_o  (win_idx),
        .win_vld_o  (win_vld)
    );

    // A request that rests only on DMA yields while any slave core asks for priority.
    assign eff_req       = core_req_i | (dma_req_i & core_prio_n_i);
    assign req_n_o       = single ? '1 : ~(own_line & {N_LINES{eff_req}});
    assign bus_master_o  = single | (own_idx == st_q.owner);
    assign core_prio_n_o = ~(core_req_i & ~bus_master_o);

    always_comb begin
        st_d = st_q;
        if (!host_act && !line_act[st_q.owner] && win_vld) begin
            st_d.owner = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= '0;
            st_q.id    <= node_id_i;
        end else begin
            st_q <= st_d;
        end
    end

    mpa_host_seq u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_i   (bus_master_o),
        .host_act_i (host_act),
        .float_o    (bus_float_o),
        .grant_o    (grant)
    );

    assign host_grant_n_o = ~grant;

endmodule

// File: rtl/mpa_arbiter_chk.sv
module mpa_arbiter_chk #(
    parameter int unsigned N_LINES = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] req_n_o,
    input logic               host_req_n_i,
    input logic               host_grant_n_o,
    input logic               bus_float_o,
    input logic               bus_master_o
);

    p_one_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~req_n_o) <= 1);

    p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_master_o) |-> ($past(&req_n_o) && $past(host_req_n_i)));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req_n_i |=> $stable(bus_master_o));

    p_float_on_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_req_n_i && bus_master_o) |=> bus_float_o);

    p_float_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_grant_n_o) |-> $past(bus_float_o));

    p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant_n_o && !host_req_n_i) |=> !host_grant_n_o);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_n_i |=> (host_grant_n_o && !bus_float_o));

    p_grant_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant_n_o || bus_float_o) |-> bus_master_o);

endmodule

bind mpa_bus_arbiter mpa_arbiter_chk #(.N_LINES(N_LINES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_n_o        (req_n_o),
    .host_req_n_i   (host_req_n_i),
    .host_grant_n_o (host_grant_n_o),
    .bus_float_o    (bus_float_o),
    .bus_master_o   (bus_master_o)
);

// File: tb/mpa_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module mpa_bus_arbiter_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       rot = 1'b0;
    logic       host_n = 1'b1;
    logic [5:0] core = '0;
    logic [5:0] dma = '0;
    logic [2:0] id_var = 3'd1;

    logic [5:0] req_n_o [6];
    logic [5:0] cpa_n_o, grant_n_o, float_o, master_o;
    logic [5:0] req_bus;
    logic       cpa_bus, grant_bus;

    logic [5:0] sp_req_n_o;
    logic       sp_cpa_n_o, sp_grant_n_o, sp_float_o, sp_master_o;

    always_comb begin
        req_bus = '1;
        for (int k = 0; k < 6; k++) req_bus = req_bus & req_n_o[k];
    end
    assign cpa_bus   = &cpa_n_o;
    assign grant_bus = &grant_n_o;

    mpa_bus_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .node_id_i(id_var), .rotate_i(rot),
        .req_lines_n_i(req_bus), .req_n_o(req_n_o[0]),
        .core_req_i(core[0]), .dma_req_i(dma[0]),
        .core_prio_n_i(cpa_bus), .core_prio_n_o(cpa_n_o[0]),
        .host_req_n_i(host_n), .host_grant_n_o(grant_n_o[0]),
        .bus_float_o(float_o[0]), .bus_master_o(master_o[0])
    );

    for (genvar g = 1; g < 6; g++) begin : g_peer
        mpa_bus_arbiter peer_i (
            .clk(clk), .rst_n(rst_n), .node_id_i(3'(g + 1)), .rotate_i(rot),
            .req_lines_n_i(req_bus), .req_n_o(req_n_o[g]),
            .core_req_i(core[g]), .dma_req_i(dma[g]),
            .core_prio_n_i(cpa_bus), .core_prio_n_o(cpa_n_o[g]),
            .host_req_n_i(host_n), .host_grant_n_o(grant_n_o[g]),
            .bus_float_o(float_o[g]), .bus_master_o(master_o[g])
        );
    end

    mpa_bus_arbiter sp_i (
        .clk(clk), .rst_n(rst_n), .node_id_i(3'd0), .rotate_i(rot),
        .req_lines_n_i(6'h3f), .req_n_o(sp_req_n_o),
        .core_req_i(core[0]), .dma_req_i(dma[0]),
        .core_prio_n_i(1'b1), .core_prio_n_o(sp_cpa_n_o),
        .host_req_n_i(host_n), .host_grant_n_o(sp_grant_n_o),
        .bus_float_o(sp_float_o), .bus_master_o(sp_master_o)
    );

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    int m_owner = 0;
    bit m_flt = 1'b0;
    bit m_gnt = 1'b0;

    always @(posedge clk) begin
        bit cpa_any;
        bit eff [6];
        int nxt;
        if (!rst_n) begin
            m_owner = 0; m_flt = 0; m_gnt = 0;
        end else begin
            cpa_any = 0;
            for (int k = 0; k < 6; k++) if (core[k] && m_owner != k) cpa_any = 1;
            for (int k = 0; k < 6; k++) eff[k] = core[k] || (dma[k] && !cpa_any);
            nxt = m_owner;
            if (host_n && !eff[m_owner]) begin
                for (int j = 0; j < 6; j++) begin
                    int c;
                    c = rot ? (m_owner + 1 + j) % 6 : j;
                    if (nxt == m_owner && eff[c]) nxt = c;
                end
            end
            m_gnt = !host_n && m_flt;
            m_flt = !host_n;
            m_owner = nxt;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            int n;
            n = 0;
            for (int k = 0; k < 6; k++) begin
                n += master_o[k];
                chk(master_o[k] == (m_owner == k), "R11 model owner", master_o, 1 << m_owner);
                chk(float_o[k] == ((m_owner == k) && m_flt), "R9 model float", float_o, m_flt << m_owner);
            end
            chk(n == 1, "R11 one master", n, 1);
            chk(grant_bus == !m_gnt, "R8 model grant", grant_bus, !m_gnt);
            chk(sp_master_o == 1'b1, "R2 single master", sp_master_o, 1);
            chk(sp_float_o == m_flt && sp_grant_n_o == !m_gnt, "R2 single host",
                {sp_float_o, sp_grant_n_o}, {m_flt, !m_gnt});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        id_var = 3'd4;
        step(1);
        cmp_en = 1'b1;
        chk(master_o == 6'b000001, "R6 reset owner", master_o, 6'b000001);
        chk(float_o == 6'b0 && grant_bus == 1'b1, "R6 reset host", {float_o, grant_bus}, 7'b1);
        chk(req_bus == 6'h3f, "R1 idle lines", req_bus, 6'h3f);

        core = 6'b000001; #1;
        chk(req_n_o[0] == 6'b111110, "R1 id sampled in reset", req_n_o[0], 6'b111110);
        chk(sp_req_n_o == 6'h3f, "R2 single drives no line", sp_req_n_o, 6'h3f);
        step(1);
        core = 6'b001000; #1;
        chk(req_bus == 6'b110111, "R1 line of id 4", req_bus, 6'b110111);
        step(1);
        core = 6'b0;
        step(1);
        chk(master_o == 6'b001000, "R3 single requester", master_o, 6'b001000);

        core = 6'b011100;
        step(1);
        chk(master_o == 6'b001000, "R5 owner keeps bus", master_o, 6'b001000);
        core = 6'b010100;
        step(1);
        chk(master_o == 6'b000100, "R3 lowest wins", master_o, 6'b000100);
        step(3);
        chk(master_o == 6'b000100, "R5 held while asserted", master_o, 6'b000100);
        core = 6'b010000;
        step(1);
        chk(master_o == 6'b010000, "R3 next lowest", master_o, 6'b010000);
        core = 6'b0;
        step(3);
        chk(master_o == 6'b010000, "R6 parked", master_o, 6'b010000);

        rot = 1'b1; core = 6'b100001;
        step(1);
        chk(master_o == 6'b100000, "R4 after-owner first", master_o, 6'b100000);
        core = 6'b000001;
        step(1);
        chk(master_o == 6'b000001, "R4 wraps", master_o, 6'b000001);
        core = 6'b0; rot = 1'b0;
        step(1);

        host_n = 1'b0; core = 6'b000110;
        step(1);
        chk(float_o == 6'b000001 && grant_bus == 1'b1, "R7 float before grant",
            {float_o, grant_bus}, 7'b0000011);
        step(1);
        chk(grant_bus == 1'b0, "R8 grant follows float", grant_bus, 0);
        step(3);
        chk(grant_bus == 1'b0 && master_o == 6'b000001, "R7 frozen, R8 held",
            {master_o, grant_bus}, 7'b0000010);
        host_n = 1'b1;
        step(1);
        chk(grant_bus == 1'b1 && float_o == 6'b0, "R8 release", {float_o, grant_bus}, 7'b1);
        chk(master_o == 6'b000010, "R3 after host", master_o, 6'b000010);
        core = 6'b0; dma = 6'b000010;
        step(2);
        chk(master_o == 6'b000010, "R5 dma owner", master_o, 6'b000010);

        core = 6'b010000; dma = 6'b000011; #1;
        chk(cpa_bus == 1'b0, "R10 slave core drives priority", cpa_bus, 0);
        chk(req_bus == 6'b101111, "R10 dma withdrawn", req_bus, 6'b101111);
        step(1);
        chk(master_o == 6'b010000, "R10 core preempts dma", master_o, 6'b010000);
        #1;
        chk(cpa_bus == 1'b1 && req_bus == 6'b101100, "R10 priority released",
            {cpa_bus, req_bus}, 7'b1101100);
        core = 6'b0; dma = 6'b0;
        step(2);

        begin
            logic [31:0] lf;
            lf = 32'h1d2c_3b4a;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                core = lf[5:0] & lf[11:6] & lf[17:12];
                dma  = lf[23:18];
                if (lf[31:27] == 5'd3) rot = ~rot;
                if (host_n) begin
                    if (lf[26:22] == 5'd9) host_n = 1'b0;
                end else if (lf[26:24] == 3'd5) begin
                    host_n = 1'b1;
                end
                step(1);
            end
        end
        host_n = 1'b1;
        step(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule